// File: doc/BRIEF.md
# Cached Virtual-to-Physical Address Translator

This block turns a 16-bit virtual address into a 15-bit physical address. The upper six address bits select a virtual page of 1024 bytes. The lower ten bits are an offset that passes through unchanged. The page-to-frame mapping comes from a single-level table of one-byte entries. The entries sit in a memory whose base address the block receives as an input. A four-entry, fully associative translation cache sits in front of that table, so a page that was translated recently needs no memory access.

A requester offers one address at a time with a valid/ready pair and a write qualifier. On a cache hit the result appears on the cycle after the request is taken. On a miss the block issues one read to the table memory and waits for the returned entry. It then answers with either a physical address or a page-fault indication. A resident entry is copied into the cache slot chosen by a rotating pointer. The cached copy of an entry keeps its own reference and dirty flags, which accesses update. A flush input empties the cache, for use after the table base changes.

Top module: `xlate_unit`

## Requirements
- R1: The physical address is the 5-bit frame number in bits 14:10 with bits 9:0 of the virtual address copied unchanged below it. The virtual page number is virtual address bits 15:10.
- R2: A request to a cached page is answered with rsp_valid exactly one cycle after it is accepted, and no table read is issued for it.
- R3: A request to an uncached page causes exactly one table read: mem_rd_en is high for one cycle, the cycle after acceptance, with mem_rd_addr = ptbr + page number, modulo 2^16.
- R4: A table entry is 8 bits: frame number in bits 4:0, resident in bit 5, dirty in bit 6, reference in bit 7. The response follows one cycle after mem_rd_valid.
- R5: A resident entry fetched on a miss is installed, so the next request to the same page is a hit.
- R6: An entry with the resident bit clear gives rsp_fault=1, rsp_pa=0 and rsp_dirty=0. It is not installed, so a repeat request misses again.
- R7: The cache holds 4 entries. Installs fill slots in rotating order starting at slot 0. A fifth distinct page replaces the oldest install, and faults do not move the pointer.
- R8: The flush input invalidates every entry in one cycle and holds req_ready low while high. A flush while a miss is outstanding stops that fill from being installed, but its response is still given.
- R9: rsp_dirty gives the cached dirty flag after the current access. That flag is the table's dirty bit, ORed with every write access to the page since it was installed. A write access sets it.
- R10: While a miss is outstanding, req_ready is low and a request held on the inputs is ignored. A mem_rd_valid with no outstanding miss is ignored.
- R11: After reset the cache is empty, rsp_valid and mem_rd_en are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Request is taken this cycle if valid |
| req_va | input | 16 | Virtual address |
| req_write | input | 1 | The access is a write |
| ptbr | input | 16 | Page-table base address |
| flush | input | 1 | Invalidate all cached translations |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_pa | output | 15 | Physical address (zero on a fault) |
| rsp_fault | output | 1 | Page not resident |
| rsp_dirty | output | 1 | Cached dirty flag after this access |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 16 | Table entry address |
| mem_rd_valid | input | 1 | Table read data present |
| mem_rd_data | input | 8 | Table entry |

## Verification
A hit answer is due one cycle after the accepting edge. A table read is due one cycle after acceptance. A miss answer is due one cycle after mem_rd_valid. The bench table memory returns data two cycles after the read strobe, so a miss completes four cycles after acceptance. A behavioural model in the bench advances on the same clock edge as the design and computes what each output must be after that edge. The outputs are compared a quarter period after every edge, so every delay above is checked on the exact cycle it falls due. Scenario checks also count table reads and responses per request, which shows hit against miss, eviction order, flush effects, and requests or data that must be ignored.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_WAIT = 1'b1
  } xs_state_e;

  // flag bit offsets above the frame field of a table entry
  localparam int FL_RES   = 0;
  localparam int FL_DTY   = 1;
  localparam int FL_REF   = 2;
  localparam int FL_COUNT = 3;

endpackage

// File: rtl/xlate_tcache.sv
module xlate_tcache #(
  parameter int N_ENT = 4,
  parameter int VPN_W = 6,
  parameter int FRM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             flush_i,
  input  logic             upd_en,
  input  logic             upd_wr,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [FRM_W-1:0] ins_frm,
  input  logic             ins_dty,
  output logic             hit_o,
  output logic [FRM_W-1:0] hit_frm_o,
  output logic             hit_dty_o
);

  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0] vld_q, vld_d;
  logic [N_ENT-1:0] dty_q, dty_d;
  logic [N_ENT-1:0] ref_q, ref_d;
  logic [N_ENT-1:0] hit_oh;
  logic [VPN_W-1:0] tag_q [N_ENT];
  logic [VPN_W-1:0] tag_d [N_ENT];
  logic [FRM_W-1:0] frm_q [N_ENT];
  logic [FRM_W-1:0] frm_d [N_ENT];
  logic [IDX_W-1:0] rr_q, rr_d;

  genvar gi;
  generate
    for (gi = 0; gi < N_ENT; gi++) begin : g_match
      assign hit_oh[gi] = vld_q[gi] && (tag_q[gi] == lk_vpn);
    end
  endgenerate

  assign hit_o = |hit_oh;

  always_comb begin
    hit_frm_o = '0;
    hit_dty_o = 1'b0;
    for (int e = 0; e < N_ENT; e++) begin
      if (hit_oh[e]) begin
        hit_frm_o = hit_frm_o | frm_q[e];
        hit_dty_o = hit_dty_o | dty_q[e];
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    dty_d = dty_q;
    ref_d = ref_q;
    rr_d  = rr_q;
    for (int e = 0; e < N_ENT; e++) begin
      tag_d[e] = tag_q[e];
      frm_d[e] = frm_q[e];
      if (flush_i) begin
        vld_d[e] = 1'b0;
      end else if (ins_en && (rr_q == IDX_W'(e))) begin
        vld_d[e] = 1'b1;
        tag_d[e] = ins_vpn;
        frm_d[e] = ins_frm;
        dty_d[e] = ins_dty;
        ref_d[e] = 1'b1;
      end else if (upd_en && hit_oh[e]) begin
        ref_d[e] = 1'b1;
        if (upd_wr) dty_d[e] = 1'b1;
      end
    end
    if (ins_en && !flush_i) begin
      rr_d = (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      ref_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      dty_q <= dty_d;
      ref_q <= ref_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      for (int e = 0; e < N_ENT; e++) begin
        tag_q[e] <= tag_d[e];
        frm_q[e] <= frm_d[e];
      end
    end
  end

  // R5: installs happen only on a miss, so two slots never match one page
  p_hit_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_oh));

  // R8: a flush leaves no valid slot behind
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0));

  // R9: a write hit leaves the dirty flag of the hit slot set
  p_write_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_wr && hit_o && !flush_i) |=>
      ((dty_q & $past(hit_oh)) == $past(hit_oh)));

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int VPN_W = 6,
  parameter int OFF_W = 10,
  parameter int FRM_W = 5,
  parameter int MA_W  = 16,
  parameter int PTE_W = FRM_W + FL_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [MA_W-1:0]  ptbr_i,
  input  logic             flush_i,
  input  logic             hit_i,
  input  logic [FRM_W-1:0] hit_frm_i,
  input  logic             hit_dty_i,
  input  logic             mem_rd_valid_i,
  input  logic [PTE_W-1:0] mem_rd_data_i,
  output logic             req_ready_o,
  output logic             upd_en_o,
  output logic             ins_en_o,
  output logic [VPN_W-1:0] ins_vpn_o,
  output logic [FRM_W-1:0] ins_frm_o,
  output logic             ins_dty_o,
  output logic             mem_rd_en_o,
  output logic [MA_W-1:0]  mem_rd_addr_o,
  output logic             rsp_valid_o,
  output logic [FRM_W+OFF_W-1:0] rsp_pa_o,
  output logic             rsp_fault_o,
  output logic             rsp_dirty_o
);

  localparam int PA_W = FRM_W + OFF_W;

  xs_state_e         state_q, state_d;
  logic [VPN_W-1:0]  pvpn_q, pvpn_d;
  logic [OFF_W-1:0]  poff_q, poff_d;
  logic              pwr_q, pwr_d;
  logic              keep_q, keep_d;
  logic              men_q, men_d;
  logic [MA_W-1:0]   maddr_q, maddr_d;
  logic              rv_q, rv_d;
  logic [PA_W-1:0]   rpa_q, rpa_d;
  logic              rf_q, rf_d;
  logic              rd_q, rd_d;
  logic              accept;
  logic              pte_res, pte_dty;

  assign req_ready_o = (state_q == XS_IDLE) && !flush_i;
  assign accept      = req_ready_o && req_valid_i;
  assign pte_res     = mem_rd_data_i[FRM_W + FL_RES];
  assign pte_dty     = mem_rd_data_i[FRM_W + FL_DTY];
  assign ins_vpn_o   = pvpn_q;
  assign ins_frm_o   = mem_rd_data_i[FRM_W-1:0];
  assign ins_dty_o   = pte_dty | pwr_q;

  always_comb begin
    state_d  = state_q;
    pvpn_d   = pvpn_q;
    poff_d   = poff_q;
    pwr_d    = pwr_q;
    keep_d   = keep_q;
    men_d    = 1'b0;
    maddr_d  = maddr_q;
    rv_d     = 1'b0;
    rpa_d    = rpa_q;
    rf_d     = 1'b0;
    rd_d     = 1'b0;
    upd_en_o = 1'b0;
    ins_en_o = 1'b0;
    unique case (state_q)
      XS_IDLE: begin
        if (accept) begin
          if (hit_i) begin
            upd_en_o = 1'b1;
            rv_d     = 1'b1;
            rpa_d    = {hit_frm_i, req_off_i};
            rd_d     = hit_dty_i | req_write_i;
          end else begin
            state_d = XS_WAIT;
            men_d   = 1'b1;
            maddr_d = ptbr_i + MA_W'(req_vpn_i);
            pvpn_d  = req_vpn_i;
            poff_d  = req_off_i;
            pwr_d   = req_write_i;
            keep_d  = 1'b1;
          end
        end
      end
      XS_WAIT: begin
        if (flush_i) keep_d = 1'b0;
        if (mem_rd_valid_i) begin
          state_d  = XS_IDLE;
          rv_d     = 1'b1;
          rf_d     = !pte_res;
          rpa_d    = pte_res ? {mem_rd_data_i[FRM_W-1:0], poff_q} : '0;
          rd_d     = pte_res && (pte_dty || pwr_q);
          ins_en_o = pte_res && keep_q && !flush_i;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      keep_q  <= 1'b0;
      men_q   <= 1'b0;
      rv_q    <= 1'b0;
      rpa_q   <= '0;
      rf_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      keep_q  <= keep_d;
      men_q   <= men_d;
      rv_q    <= rv_d;
      rpa_q   <= rpa_d;
      rf_q    <= rf_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pvpn_q  <= pvpn_d;
      poff_q  <= poff_d;
      pwr_q   <= pwr_d;
      maddr_q <= maddr_d;
    end
  end

  assign mem_rd_en_o   = men_q;
  assign mem_rd_addr_o = maddr_q;
  assign rsp_valid_o   = rv_q;
  assign rsp_pa_o      = rpa_q;
  assign rsp_fault_o   = rf_q;
  assign rsp_dirty_o   = rd_q;

  // R3: the table read strobe lasts a single cycle
  p_read_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |=> !mem_rd_en_o);

  // R3: a miss is followed by a read of base plus page number
  p_miss_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit_i) |=>
      (mem_rd_en_o && (mem_rd_addr_o == $past(ptbr_i) + MA_W'($past(req_vpn_i)))));

  // R2: a hit answers on the next cycle with no table read
  p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit_i) |=> (rsp_valid_o && !rsp_fault_o && !mem_rd_en_o));

  // R6: a fault response carries no address
  p_fault_pa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_o |-> (rsp_valid_o && (rsp_pa_o == '0) && !rsp_dirty_o));

  // R10: no new request is taken while a miss is outstanding
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_WAIT) |-> !req_ready_o);

endmodule

// File: rtl/xlate_unit.sv
module xlate_unit #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 10,
  parameter int PA_W  = 15,
  parameter int N_ENT = 4,
  parameter int MA_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_va,
  input  logic                    req_write,
  input  logic [MA_W-1:0]         ptbr,
  input  logic                    flush,
  output logic                    rsp_valid,
  output logic [PA_W-1:0]         rsp_pa,
  output logic                    rsp_fault,
  output logic                    rsp_dirty,
  output logic                    mem_rd_en,
  output logic [MA_W-1:0]         mem_rd_addr,
  input  logic                    mem_rd_valid,
  input  logic [PA_W-OFF_W+2:0]   mem_rd_data
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int FRM_W = PA_W - OFF_W;
  localparam int PTE_W = FRM_W + xlate_pkg::FL_COUNT;

  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  logic             hit, hit_dty, upd_en, ins_en, ins_dty;
  logic [FRM_W-1:0] hit_frm, ins_frm;
  logic [VPN_W-1:0] ins_vpn;

  assign vpn = req_va[VA_W-1:OFF_W];
  assign off = req_va[OFF_W-1:0];

  xlate_tcache #(
    .N_ENT(N_ENT), .VPN_W(VPN_W), .FRM_W(FRM_W)
  ) u_tcache (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (vpn),
    .flush_i  (flush),
    .upd_en   (upd_en),
    .upd_wr   (req_write),
    .ins_en   (ins_en),
    .ins_vpn  (ins_vpn),
    .ins_frm  (ins_frm),
    .ins_dty  (ins_dty),
    .hit_o    (hit),
    .hit_frm_o(hit_frm),
    .hit_dty_o(hit_dty)
  );

  xlate_ctrl #(
    .VPN_W(VPN_W), .OFF_W(OFF_W), .FRM_W(FRM_W), .MA_W(MA_W), .PTE_W(PTE_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid),
    .req_write_i   (req_write),
    .req_vpn_i     (vpn),
    .req_off_i     (off),
    .ptbr_i        (ptbr),
    .flush_i       (flush),
    .hit_i         (hit),
    .hit_frm_i     (hit_frm),
    .hit_dty_i     (hit_dty),
    .mem_rd_valid_i(mem_rd_valid),
    .mem_rd_data_i (mem_rd_data),
    .req_ready_o   (req_ready),
    .upd_en_o      (upd_en),
    .ins_en_o      (ins_en),
    .ins_vpn_o     (ins_vpn),
    .ins_frm_o     (ins_frm),
    .ins_dty_o     (ins_dty),
    .mem_rd_en_o   (mem_rd_en),
    .mem_rd_addr_o (mem_rd_addr),
    .rsp_valid_o   (rsp_valid),
    .rsp_pa_o      (rsp_pa),
    .rsp_fault_o   (rsp_fault),
    .rsp_dirty_o   (rsp_dirty)
  );

endmodule

// File: tb/xlate_unit_bench.sv
module xlate_unit_bench;

  localparam int PERIOD = 10;
  localparam int LAT    = 2;
  localparam int NE     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, flush = 1'b0;
  logic [15:0] req_va = '0, ptbr = 16'h0020;
  logic        req_ready, rsp_valid, rsp_fault, rsp_dirty, mem_rd_en;
  logic [14:0] rsp_pa;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [7:0]  mem_rd_data = '0;

  xlate_unit u_xlate_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .ptbr(ptbr), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_dirty(rsp_dirty), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, n_rsp = 0, n_rd = 0, cyc = 0;
  int last_pa = 0, last_fault = 0, last_dty = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // table contents: frame, resident, dirty computed from the entry address
  function automatic logic [7:0] pte_of(input logic [15:0] a);
    logic [7:0] p;
    p[4:0] = 5'((int'(a) * 7 + 3) % 32);
    p[5]   = (int'(a) % 5) != 0;
    p[6]   = (int'(a) % 4) == 0;
    p[7]   = 1'b0;
    return p;
  endfunction

  function automatic int exp_pa(input logic [15:0] a, input int off);
    return (int'(pte_of(a)[4:0]) << 10) | off;
  endfunction

  // behavioural reference model
  int m_state = 0, m_keep = 0, m_rr = 0;
  int m_vld[NE], m_tag[NE], m_frm[NE], m_dty[NE];
  int m_rv = 0, m_pa = 0, m_f = 0, m_rd = 0, m_men = 0, m_maddr = 0, m_from_wait = 0;
  int p_vpn = 0, p_off = 0, p_wr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_rr = 0; m_rv = 0; m_men = 0; m_keep = 0;
      for (int e = 0; e < NE; e++) m_vld[e] = 0;
    end else begin
      m_rv = 0; m_men = 0; m_from_wait = 0;
      if (m_state == 0) begin
        if (flush) begin
          for (int e = 0; e < NE; e++) m_vld[e] = 0;
        end else if (req_valid) begin
          int vpn, h;
          vpn = int'(req_va[15:10]);
          h = -1;
          for (int e = 0; e < NE; e++) if (m_vld[e] != 0 && m_tag[e] == vpn) h = e;
          if (h >= 0) begin
            if (req_write) m_dty[h] = 1;
            m_rv = 1; m_f = 0; m_rd = m_dty[h];
            m_pa = (m_frm[h] << 10) | int'(req_va[9:0]);
          end else begin
            m_state = 1; m_men = 1; m_keep = 1;
            m_maddr = (int'(ptbr) + vpn) % 65536;
            p_vpn = vpn; p_off = int'(req_va[9:0]); p_wr = int'(req_write);
          end
        end
      end else begin
        if (flush) begin
          for (int e = 0; e < NE; e++) m_vld[e] = 0;
          m_keep = 0;
        end
        if (mem_rd_valid) begin
          m_rv = 1; m_from_wait = 1; m_state = 0;
          if (mem_rd_data[5]) begin
            m_f = 0;
            m_pa = (int'(mem_rd_data[4:0]) << 10) | p_off;
            m_rd = (mem_rd_data[6] || p_wr != 0) ? 1 : 0;
            if (m_keep != 0) begin
              m_vld[m_rr] = 1; m_tag[m_rr] = p_vpn;
              m_frm[m_rr] = int'(mem_rd_data[4:0]); m_dty[m_rr] = m_rd;
              m_rr = (m_rr + 1) % NE;
            end
          end else begin
            m_f = 1; m_pa = 0; m_rd = 0;
          end
        end
      end
    end
    #(PERIOD/4);
    cyc++;
    if (rst_n) begin
      chk(int'(rsp_valid) == m_rv, m_from_wait != 0 ? "R4" : "R2", "rsp_valid",
          int'(rsp_valid), m_rv);
      if (m_rv != 0 && rsp_valid) begin
        chk(int'(rsp_pa) == m_pa, "R1", "rsp_pa", int'(rsp_pa), m_pa);
        chk(int'(rsp_fault) == m_f, "R6", "rsp_fault", int'(rsp_fault), m_f);
        chk(int'(rsp_dirty) == m_rd, "R9", "rsp_dirty", int'(rsp_dirty), m_rd);
      end
      chk(int'(mem_rd_en) == m_men, "R3", "mem_rd_en", int'(mem_rd_en), m_men);
      if (m_men != 0)
        chk(int'(mem_rd_addr) == m_maddr, "R3", "mem_rd_addr", int'(mem_rd_addr), m_maddr);
      chk(int'(req_ready) == ((m_state == 0 && !flush) ? 1 : 0), "R10", "req_ready",
          int'(req_ready), (m_state == 0 && !flush) ? 1 : 0);
      if (rsp_valid) begin
        n_rsp++; last_pa = int'(rsp_pa); last_fault = int'(rsp_fault); last_dty = int'(rsp_dirty);
      end
      if (mem_rd_en) n_rd++;
    end
    if (cyc > 20000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // table memory responder
  bit stray_req = 1'b0, stray_seen = 1'b0;
  int rcnt = 0;
  logic [15:0] raddr = '0;
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (rcnt > 0) begin
      rcnt--;
      if (rcnt == 0) begin mem_rd_valid = 1'b1; mem_rd_data = pte_of(raddr); end
    end
    if (mem_rd_en) begin raddr = mem_rd_addr; rcnt = LAT; end
    if (stray_req != stray_seen) begin
      stray_seen = stray_req; mem_rd_valid = 1'b1; mem_rd_data = 8'hFF;
    end
  end

  int r_miss, r_fault, r_dty, r_pa;

  task automatic access(input logic [15:0] va, input bit wr, input int mode,
                        input logic [15:0] va2);
    int rd0, rs0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd0 = n_rd; rs0 = n_rsp;
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    if (mode == 1) begin flush = 1'b1; @(negedge clk); flush = 1'b0; end
    if (mode == 2) begin
      req_valid = 1'b1; req_va = va2; req_write = 1'b0;
      @(negedge clk); req_valid = 1'b0;
    end
    while (n_rsp == rs0) @(negedge clk);
    r_miss = (n_rd != rd0) ? 1 : 0;
    r_fault = last_fault; r_dty = last_dty; r_pa = last_pa;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  function automatic logic [15:0] va_of(input int vpn, input int off);
    return 16'((vpn << 10) | off);
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    #(PERIOD/4);
    chk(rsp_valid == 1'b0, "R11", "reset rsp_valid", int'(rsp_valid), 0);
    chk(mem_rd_en == 1'b0, "R11", "reset mem_rd_en", int'(mem_rd_en), 0);
    chk(req_ready == 1'b1, "R11", "reset req_ready", int'(req_ready), 1);
    @(negedge clk); rst_n = 1'b1;

    // first touch of page 1: miss, offset passes through
    access(va_of(1, 16'h2AB), 1'b0, 0, '0);
    chk(r_miss == 1, "R3", "first access misses", r_miss, 1);
    chk(r_pa == exp_pa(16'd33, 'h2AB), "R1", "miss pa", r_pa, exp_pa(16'd33, 'h2AB));
    chk(r_dty == 0, "R9", "clean page dirty", r_dty, 0);
    access(va_of(1, 1), 1'b1, 0, '0);
    chk(r_miss == 0, "R5", "installed page hits", r_miss, 0);
    chk(r_dty == 1, "R9", "write sets dirty", r_dty, 1);
    access(va_of(1, 'h3FF), 1'b0, 0, '0);
    chk(r_dty == 1, "R9", "dirty kept on read", r_dty, 1);
    chk(r_pa == exp_pa(16'd33, 'h3FF), "R1", "hit pa", r_pa, exp_pa(16'd33, 'h3FF));

    // page 3 is not resident
    access(va_of(3, 5), 1'b0, 0, '0);
    chk(r_fault == 1, "R6", "fault raised", r_fault, 1);
    access(va_of(3, 5), 1'b0, 0, '0);
    chk(r_miss == 1, "R6", "fault not installed", r_miss, 1);

    // rotation: slots 0..3 = 1,2,4,5; then 6 replaces 1, 1 replaces 2
    access(va_of(2, 0), 1'b0, 0, '0);
    access(va_of(4, 0), 1'b0, 0, '0);
    access(va_of(5, 0), 1'b0, 0, '0);
    access(va_of(6, 0), 1'b0, 0, '0);
    access(va_of(1, 0), 1'b0, 0, '0);
    chk(r_miss == 1, "R7", "oldest page evicted", r_miss, 1);
    access(va_of(4, 7), 1'b0, 0, '0);
    chk(r_miss == 0, "R7", "younger page kept", r_miss, 0);
    access(va_of(5, 7), 1'b0, 0, '0);
    chk(r_miss == 0, "R7", "younger page kept", r_miss, 0);
    access(va_of(2, 7), 1'b0, 0, '0);
    chk(r_miss == 1, "R7", "second oldest evicted", r_miss, 1);

    // stray read data while idle
    begin
      int rs0;
      rs0 = n_rsp;
      @(negedge clk); stray_req = ~stray_req;
      repeat (3) @(negedge clk);
      chk(n_rsp == rs0, "R10", "stray data ignored", n_rsp, rs0);
    end

    // flush empties the cache
    do_flush();
    access(va_of(5, 9), 1'b0, 0, '0);
    chk(r_miss == 1, "R8", "miss after flush", r_miss, 1);

    // flush while a fill is pending
    access(va_of(7, 3), 1'b0, 1, '0);
    chk(r_pa == exp_pa(16'd39, 3), "R8", "pending fill answered", r_pa, exp_pa(16'd39, 3));
    access(va_of(7, 3), 1'b0, 0, '0);
    chk(r_miss == 1, "R8", "flushed fill not installed", r_miss, 1);

    // request offered during a pending miss is ignored
    begin
      int rs0;
      rs0 = n_rsp;
      access(va_of(9, 1), 1'b0, 2, va_of(12, 1));
      repeat (3) @(negedge clk);
      chk(n_rsp == rs0 + 1, "R10", "one response only", n_rsp, rs0 + 1);
      access(va_of(12, 1), 1'b0, 0, '0);
      chk(r_miss == 1, "R10", "ignored request left no entry", r_miss, 1);
    end

    // base near the top of the address range wraps the entry address
    @(negedge clk); ptbr = 16'hFFF0;
    do_flush();
    access(va_of(18, 'h155), 1'b0, 0, '0);
    chk(r_pa == exp_pa(16'h0002, 'h155), "R3", "wrapped entry address", r_pa,
        exp_pa(16'h0002, 'h155));
    access(va_of(19, 2), 1'b1, 0, '0);
    chk(r_dty == 1, "R9", "write miss installs dirty", r_dty, 1);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule